// File: doc/BRIEF.md
# Single-Transfer Memory-Mapped Master Bridge

This block sits between a processor's load/store port and a memory-mapped slave bus that uses a wait-request handshake. It takes one load or store at a time and turns it into plain single read or write transfers on the slave bus. It never issues a burst. It never starts a transfer before the previous one has finished. A slave can hold `av_waitrequest` for any number of cycles, and the bridge keeps every bus output frozen until the wait is released.

A request can name a byte, a halfword or a full word at any byte address. The bridge always drives a word-aligned bus address. It picks the byte lanes through `av_byteenable` and moves the store data into those lanes. A load result is shifted back down to bit 0 and zero-extended. An access that runs past the end of a word is split into two transfers: the lower word goes first, then the next word. The processor sees one acknowledge only after both transfers are done.

Top module: `mm_single_bridge`

## Requirements
- R1: A synchronous active-high reset returns the bridge to idle. In the cycle after reset is sampled, `av_read`, `av_write` and `cpu_ack` are low and `cpu_rdata` is zero. A split access that was under way is dropped and never resumes.
- R2: The bus address is the request address with its low two bits cleared. `cpu_size` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is also treated as word. The byte enables are the size mask (1, 3 or 15) shifted left by the low two address bits. Bits 0..3 of that mask go to the first transfer and bits 4..7 go to the second.
- R3: On a store, request byte i appears on byte lane (offset + i) of the shifted 64-bit pair. Lanes that are not enabled carry zero.
- R4: On a load, acknowledged data holds the addressed bytes with the lowest address at bits 7:0, and zeros above the access size. A store acknowledge returns zero data.
- R5: While `av_read` or `av_write` is high and `av_waitrequest` is high, address, byte enables, write data, read and write hold their values into the next cycle.
- R6: Read data is captured only in the cycle where the read is high and `av_waitrequest` is low. Values presented during wait cycles have no effect.
- R7: A straddling access makes exactly two transfers, lower word first and then address + 4. The acknowledge follows the second one only.
- R8: `av_read` and `av_write` are never high together. Both are low while idle, including the acknowledge cycle.
- R9: `cpu_ack` is a single-cycle pulse. It is raised in the cycle right after the last transfer completes. A new request may be presented in that same cycle.
- R10: A request raised while an access is in progress is ignored. It starts no transfer and changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request strobe, taken when idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data, right-aligned |
| cpu_size | input | 2 | Access size code |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| av_address | output | ADDR_W | Word-aligned bus address |
| av_read | output | 1 | Bus read strobe |
| av_write | output | 1 | Bus write strobe |
| av_byteenable | output | DATA_W/8 | Byte lane enables |
| av_writedata | output | DATA_W | Lane-placed store data |
| av_readdata | input | DATA_W | Slave read data |
| av_waitrequest | input | 1 | Slave stall |

## Verification
The acknowledge of one access and the acceptance of the next request fall in the same cycle. The bench therefore raises every new request in the very cycle it observes the previous `cpu_ack`. A scoreboard tagged by access number then judges the result: each acknowledge must come after the last expected transfer of its own access, and before any transfer of the following access. A second overlap, reset arriving while the upper half of a split read is stalled, is provoked by holding wait states. It is judged by the bus going quiet and no stray acknowledge appearing afterwards.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

   // access size code presented by the processor side
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   // transfer phase of the sequencer
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LO   = 2'd1,
      PH_HI   = 2'd2
   } phase_e;

endpackage

// File: rtl/mmb_lane_plan.sv
// Places the request bytes onto a double-word lane pair and derives the
// byte enables of the lower and upper transfer.
module mmb_lane_plan #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFS_W = $clog2(BYTES)
) (
   input  logic [OFS_W-1:0]  off,
   input  logic [OFS_W:0]    nbytes,
   input  logic [DATA_W-1:0] wdata,
   output logic [BYTES-1:0]  be_lo,
   output logic [BYTES-1:0]  be_hi,
   output logic [DATA_W-1:0] wd_lo,
   output logic [DATA_W-1:0] wd_hi,
   output logic              straddle
);

   for (genvar j = 0; j < 2 * BYTES; j++) begin : g_lane
      logic       sel;
      logic [7:0] byte_v;

      // lane j carries request byte (j - off) when that byte exists
      always_comb begin
         sel    = 1'b0;
         byte_v = 8'h00;
         for (int o = 0; o < BYTES; o++) begin
            if (int'(off) == o && j >= o && (j - o) < int'(nbytes)) begin
               sel    = 1'b1;
               byte_v = wdata[((j - o) % BYTES) * 8 +: 8];
            end
         end
      end

      if (j < BYTES) begin : g_lo
         assign be_lo[j]          = sel;
         assign wd_lo[j*8 +: 8]   = byte_v;
      end else begin : g_hi
         assign be_hi[j-BYTES]             = sel;
         assign wd_hi[(j-BYTES)*8 +: 8]    = byte_v;
      end
   end

   assign straddle = |be_hi;

   // R2: the enabled lanes of both halves add up to the access size
   always_comb begin
      a_r2_lane_count: assert ($countones({be_hi, be_lo}) == int'(nbytes));
   end

endmodule

// File: rtl/mmb_read_merge.sv
// Picks the addressed bytes out of the captured word pair, moves them down
// to bit 0 and clears every byte above the access size.
module mmb_read_merge #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFS_W = $clog2(BYTES)
) (
   input  logic [DATA_W-1:0] lo_word,
   input  logic [DATA_W-1:0] hi_word,
   input  logic [OFS_W-1:0]  off,
   input  logic [OFS_W:0]    nbytes,
   output logic [DATA_W-1:0] rdata
);

   logic [2*DATA_W-1:0] pair;
   assign pair = {hi_word, lo_word};

   for (genvar i = 0; i < BYTES; i++) begin : g_out
      logic [7:0] b;
      always_comb begin
         b = 8'h00;
         for (int o = 0; o < BYTES; o++) begin
            if (int'(off) == o && i < int'(nbytes)) begin
               b = pair[(i + o) * 8 +: 8];
            end
         end
      end
      assign rdata[i*8 +: 8] = b;
   end

endmodule

// File: rtl/mmb_seq.sv
// Transfer sequencer: latches one request, runs the lower and (if needed)
// upper bus transfer, stretches on wait-request and pulses the acknowledge.
module mmb_seq
   import mmb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFS_W = $clog2(BYTES),
   localparam int WA_W  = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [1:0]        cpu_size,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic [ADDR_W-1:0] av_address,
   output logic              av_read,
   output logic              av_write,
   output logic [BYTES-1:0]  av_byteenable,
   output logic [DATA_W-1:0] av_writedata,
   input  logic [DATA_W-1:0] av_readdata,
   input  logic              av_waitrequest,
   output logic [OFS_W-1:0]  pl_off,
   output logic [OFS_W:0]    pl_nbytes,
   output logic [DATA_W-1:0] pl_wdata,
   input  logic [BYTES-1:0]  pl_be_lo,
   input  logic [BYTES-1:0]  pl_be_hi,
   input  logic [DATA_W-1:0] pl_wd_lo,
   input  logic [DATA_W-1:0] pl_wd_hi,
   input  logic              pl_straddle,
   output logic [DATA_W-1:0] mg_lo,
   output logic [DATA_W-1:0] mg_hi,
   input  logic [DATA_W-1:0] mg_data
);

   phase_e            st_q;
   logic [WA_W-1:0]   wa_q;
   logic [OFS_W-1:0]  off_q;
   logic [OFS_W:0]    nb_q;
   logic              we_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] rd_q;
   logic              ack_q;
   logic [OFS_W:0]    req_nb;
   logic              busy;
   logic              hi_ph;
   logic              beat_done;

   // size code to byte count; the reserved code falls back to a full word
   always_comb begin
      if (size_e'(cpu_size) == SZ_BYTE)      req_nb = (OFS_W+1)'(1);
      else if (size_e'(cpu_size) == SZ_HALF) req_nb = (OFS_W+1)'(2);
      else                                   req_nb = (OFS_W+1)'(BYTES);
   end

   assign busy      = (st_q != PH_IDLE);
   assign hi_ph     = (st_q == PH_HI);
   assign beat_done = busy && !av_waitrequest;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= PH_IDLE;
         wa_q  <= '0;
         off_q <= '0;
         nb_q  <= '0;
         we_q  <= 1'b0;
         wd_q  <= '0;
         lo_q  <= '0;
         rd_q  <= '0;
         ack_q <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (st_q)
            PH_IDLE: begin
               if (cpu_req) begin
                  wa_q  <= cpu_addr[ADDR_W-1:OFS_W];
                  off_q <= cpu_addr[OFS_W-1:0];
                  nb_q  <= req_nb;
                  we_q  <= cpu_we;
                  wd_q  <= cpu_wdata;
                  st_q  <= PH_LO;
               end
            end
            PH_LO: begin
               if (beat_done) begin
                  if (pl_straddle) begin
                     lo_q <= av_readdata;
                     st_q <= PH_HI;
                  end else begin
                     ack_q <= 1'b1;
                     rd_q  <= we_q ? '0 : mg_data;
                     st_q  <= PH_IDLE;
                  end
               end
            end
            PH_HI: begin
               if (beat_done) begin
                  ack_q <= 1'b1;
                  rd_q  <= we_q ? '0 : mg_data;
                  st_q  <= PH_IDLE;
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   assign av_address    = {wa_q + WA_W'(hi_ph), {OFS_W{1'b0}}};
   assign av_read       = busy && !we_q;
   assign av_write      = busy && we_q;
   assign av_byteenable = !busy ? '0 : (hi_ph ? pl_be_hi : pl_be_lo);
   assign av_writedata  = hi_ph ? pl_wd_hi : pl_wd_lo;

   assign pl_off    = off_q;
   assign pl_nbytes = nb_q;
   assign pl_wdata  = wd_q;
   assign mg_lo     = hi_ph ? lo_q : av_readdata;
   assign mg_hi     = av_readdata;

   assign cpu_ack   = ack_q;
   assign cpu_rdata = rd_q;

   // R8: read and write strobes are exclusive
   a_r8_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
      !(av_read && av_write));

   // R8: the bus is quiet while the acknowledge is shown
   a_r8_quiet_on_ack: assert property (@(posedge clk) disable iff (rst)
      cpu_ack |-> (!av_read && !av_write));

   // R5: everything the slave sees is frozen across a stall
   a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
      ((av_read || av_write) && av_waitrequest) |=>
         ($stable(av_address) && $stable(av_byteenable) &&
          $stable(av_writedata) && $stable(av_read) && $stable(av_write)));

   // R2: bus address is word aligned and at least one lane is enabled
   a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
      (av_read || av_write) |->
         (av_address[OFS_W-1:0] == '0 && av_byteenable != '0));

   // R9: the acknowledge lasts one cycle
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      cpu_ack |=> !cpu_ack);

   // R7: an acknowledge follows a completed transfer
   a_r7_ack_after_beat: assert property (@(posedge clk) disable iff (rst)
      cpu_ack |-> $past((av_read || av_write) && !av_waitrequest));

   // R1: the cycle after reset the bus and acknowledge are released
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!av_read && !av_write && !cpu_ack));

endmodule

// File: rtl/mm_single_bridge.sv
module mm_single_bridge #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFS_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [1:0]        cpu_size,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic [ADDR_W-1:0] av_address,
   output logic              av_read,
   output logic              av_write,
   output logic [BYTES-1:0]  av_byteenable,
   output logic [DATA_W-1:0] av_writedata,
   input  logic [DATA_W-1:0] av_readdata,
   input  logic              av_waitrequest
);

   // elaboration-time parameter checks
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("mm_single_bridge: DATA_W must be a power of two of at least 16");
   end
   if (ADDR_W <= OFS_W + 1) begin : g_bad_addr_w
      $error("mm_single_bridge: ADDR_W too small for the word size");
   end

   logic [OFS_W-1:0]  pl_off;
   logic [OFS_W:0]    pl_nbytes;
   logic [DATA_W-1:0] pl_wdata;
   logic [BYTES-1:0]  pl_be_lo;
   logic [BYTES-1:0]  pl_be_hi;
   logic [DATA_W-1:0] pl_wd_lo;
   logic [DATA_W-1:0] pl_wd_hi;
   logic              pl_straddle;
   logic [DATA_W-1:0] mg_lo;
   logic [DATA_W-1:0] mg_hi;
   logic [DATA_W-1:0] mg_data;

   mmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk            (clk),
      .rst            (rst),
      .cpu_req        (cpu_req),
      .cpu_we         (cpu_we),
      .cpu_addr       (cpu_addr),
      .cpu_wdata      (cpu_wdata),
      .cpu_size       (cpu_size),
      .cpu_rdata      (cpu_rdata),
      .cpu_ack        (cpu_ack),
      .av_address     (av_address),
      .av_read        (av_read),
      .av_write       (av_write),
      .av_byteenable  (av_byteenable),
      .av_writedata   (av_writedata),
      .av_readdata    (av_readdata),
      .av_waitrequest (av_waitrequest),
      .pl_off         (pl_off),
      .pl_nbytes      (pl_nbytes),
      .pl_wdata       (pl_wdata),
      .pl_be_lo       (pl_be_lo),
      .pl_be_hi       (pl_be_hi),
      .pl_wd_lo       (pl_wd_lo),
      .pl_wd_hi       (pl_wd_hi),
      .pl_straddle    (pl_straddle),
      .mg_lo          (mg_lo),
      .mg_hi          (mg_hi),
      .mg_data        (mg_data)
   );

   mmb_lane_plan #(.DATA_W(DATA_W)) u_plan (
      .off      (pl_off),
      .nbytes   (pl_nbytes),
      .wdata    (pl_wdata),
      .be_lo    (pl_be_lo),
      .be_hi    (pl_be_hi),
      .wd_lo    (pl_wd_lo),
      .wd_hi    (pl_wd_hi),
      .straddle (pl_straddle)
   );

   mmb_read_merge #(.DATA_W(DATA_W)) u_merge (
      .lo_word (mg_lo),
      .hi_word (mg_hi),
      .off     (pl_off),
      .nbytes  (pl_nbytes),
      .rdata   (mg_data)
   );

endmodule

// File: tb/mm_single_bridge_test.sv
module mm_single_bridge_test;

   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [1:0]    cpu_size = 2'd0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_ack;
   logic [AW-1:0] av_address;
   logic          av_read;
   logic          av_write;
   logic [3:0]    av_byteenable;
   logic [DW-1:0] av_writedata;
   logic [DW-1:0] av_readdata;
   logic          av_waitrequest;

   always #2 clk = ~clk;

   mm_single_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_size(cpu_size),
      .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
      .av_address(av_address), .av_read(av_read), .av_write(av_write),
      .av_byteenable(av_byteenable), .av_writedata(av_writedata),
      .av_readdata(av_readdata), .av_waitrequest(av_waitrequest)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- slave model ----------------
   logic [7:0] smem [32];
   logic [7:0] rmem [32];
   int wait_cfg = 0;
   int wait_left = 0;
   int cyc = 0;

   assign av_waitrequest = (av_read || av_write) && (wait_left != 0);
   assign av_readdata = av_waitrequest ? {16'hDEAD, cyc[15:0]} :
      {smem[{av_address[4:2], 2'd3}], smem[{av_address[4:2], 2'd2}],
       smem[{av_address[4:2], 2'd1}], smem[{av_address[4:2], 2'd0}]};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst || !(av_read || av_write)) begin
         wait_left <= wait_cfg;
      end else if (wait_left != 0) begin
         wait_left <= wait_left - 1;
      end else begin
         wait_left <= wait_cfg;
         if (av_write) begin
            for (int b = 0; b < 4; b++)
               if (av_byteenable[b])
                  smem[{av_address[4:2], 2'(b)}] <= av_writedata[b*8 +: 8];
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      int          id;
      bit          we;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wd;
   } xf_t;

   typedef struct {
      int          id;
      bit          we;
      logic [31:0] rd;
   } ak_t;

   xf_t xq[$];
   ak_t aq[$];
   int  acc_id = 0;

   // expected transfers and result, from the lane rules of R2, R3, R4, R7
   task automatic expect_access(input bit we, input logic [31:0] a,
                                input logic [1:0] sz, input logic [31:0] wd,
                                input bit full);
      int          nb;
      int          off;
      logic [7:0]  m8;
      logic [31:0] wmask;
      logic [63:0] w64;
      logic [31:0] rd;
      xf_t         x;
      ak_t         k;
      nb    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      off   = int'(a[1:0]);
      m8    = 8'(((1 << nb) - 1) << off);
      wmask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
      w64   = {32'h0, wd & wmask} << (8 * off);
      rd    = '0;
      acc_id++;
      x.id = acc_id; x.we = we; x.addr = {a[31:2], 2'b00};
      x.be = m8[3:0]; x.wd = w64[31:0];
      xq.push_back(x);
      if (m8[7:4] != 4'h0 && full) begin
         x.addr = x.addr + 32'd4; x.be = m8[7:4]; x.wd = w64[63:32];
         xq.push_back(x);
      end
      for (int i = 0; i < nb; i++) begin
         if (we) rmem[5'(a + 32'(i))] = wd[i*8 +: 8];
         else    rd[i*8 +: 8] = rmem[5'(a + 32'(i))];
      end
      k.id = acc_id; k.we = we; k.rd = rd;
      if (full) aq.push_back(k);
   endtask

   // driver: called at a falling edge, returns at the falling edge showing ack
   task automatic access(input bit we, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] wd,
                         input int waits);
      wait_cfg = waits;
      expect_access(we, a, sz, wd, 1'b1);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      while (!cpu_ack) @(negedge clk);
   endtask

   // ---------------- monitor ----------------
   logic        rst_at_edge = 1'b1;
   logic [31:0] p_addr = '0;
   logic [31:0] p_wd = '0;
   logic [3:0]  p_be = '0;
   logic        p_rd = 1'b0;
   logic        p_wr = 1'b0;
   logic        p_wait = 1'b0;
   logic        p_ack = 1'b0;
   xf_t         mx;
   ak_t         mk;

   always @(posedge clk) rst_at_edge <= rst;

   always @(negedge clk) begin
      if (!rst_at_edge) begin
         if (p_wait)
            check(av_address == p_addr && av_byteenable == p_be &&
                  av_writedata == p_wd && av_read == p_rd && av_write == p_wr,
                  "R5", "outputs moved during wait",
                  {av_address, av_writedata}, {p_addr, p_wd});
         if (av_read || av_write)
            check(!(av_read && av_write), "R8", "read and write together",
                  {62'h0, av_read, av_write}, 64'h0);
         if ((av_read || av_write) && !av_waitrequest) begin
            if (xq.size() == 0) begin
               check(1'b0, "R10", "unexpected transfer", 64'(av_address), 64'h0);
            end else begin
               mx = xq.pop_front();
               check(av_address == mx.addr, "R2", "address",
                     64'(av_address), 64'(mx.addr));
               check(av_byteenable == mx.be, "R2", "byteenable",
                     64'(av_byteenable), 64'(mx.be));
               check(av_write == mx.we && av_read == !mx.we, "R8", "direction",
                     {62'h0, av_read, av_write}, {62'h0, !mx.we, mx.we});
               if (mx.we)
                  check(av_writedata == mx.wd, "R3", "writedata",
                        64'(av_writedata), 64'(mx.wd));
            end
         end
         if (cpu_ack) begin
            check(!p_ack, "R9", "ack longer than one cycle", 64'(p_ack), 64'h0);
            if (aq.size() == 0) begin
               check(1'b0, "R9", "unexpected ack", 64'h1, 64'h0);
            end else begin
               mk = aq.pop_front();
               check(xq.size() == 0 || xq[0].id > mk.id, "R7",
                     "ack before final transfer", 64'(xq.size()), 64'h0);
               check(!av_read && !av_write, "R8", "bus busy during ack",
                     {62'h0, av_read, av_write}, 64'h0);
               check(cpu_rdata == mk.rd, "R4 R6", "returned data",
                     64'(cpu_rdata), 64'(mk.rd));
            end
         end
      end
      p_wait = !rst_at_edge && (av_read || av_write) && av_waitrequest;
      p_addr = av_address; p_wd = av_writedata; p_be = av_byteenable;
      p_rd = av_read; p_wr = av_write; p_ack = cpu_ack;
   end

   // ---------------- watchdog ----------------
   bit done = 1'b0;
   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 32; i++) begin
         smem[i] = 8'(8'h40 + i);
         rmem[i] = 8'(8'h40 + i);
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check(!av_read && !av_write && !cpu_ack && cpu_rdata == '0, "R1",
            "reset state", {30'h0, av_read, av_write, cpu_ack, cpu_rdata},
            64'h0);

      // aligned word store and load, with and without stalls
      access(1'b1, 32'h0000_0000, 2'd2, 32'h1122_3344, 0);
      access(1'b0, 32'h0000_0000, 2'd2, 32'h0, 2);
      repeat (2) @(negedge clk);

      // every offset, every size: store then load back (R2 R3 R4 R7)
      for (int off = 0; off < 4; off++) begin
         for (int sz = 0; sz < 3; sz++) begin
            access(1'b1, 32'(8 + off), 2'(sz),
                   32'hA5C3_0F00 ^ 32'(off * 16 + sz), (off + sz) % 3);
            access(1'b0, 32'(8 + off), 2'(sz), 32'h0, (off + 2 * sz) % 4);
            if (off == 2) @(negedge clk);
         end
      end

      // reserved size code acts as a full word (R2), straddling offset 3
      access(1'b1, 32'h0000_0017, 2'd3, 32'hCAFE_F00D, 1);
      access(1'b0, 32'h0000_0017, 2'd2, 32'h0, 0);

      // straddle across the end of the modelled memory (R7)
      access(1'b1, 32'h0000_001E, 2'd2, 32'h8765_4321, 2);
      access(1'b0, 32'h0000_001D, 2'd2, 32'h0, 3);
      access(1'b0, 32'h0000_001F, 2'd1, 32'h0, 1);

      // request ignored while busy (R10)
      wait_cfg = 6;
      expect_access(1'b0, 32'h0000_0008, 2'd2, 32'h0, 1'b1);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h8; cpu_size = 2'd2;
      @(negedge clk);
      cpu_req = 1'b0;
      repeat (2) @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h4; cpu_size = 2'd2;
      cpu_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cpu_req = 1'b0;
      while (!cpu_ack) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!av_read && !av_write, "R10", "stray request started",
               {62'h0, av_read, av_write}, 64'h0);
      end
      access(1'b0, 32'h0000_0004, 2'd2, 32'h0, 0);   // R10 memory untouched
      repeat (2) @(negedge clk);

      // reset during the stalled upper half of a split read (R1)
      wait_cfg = 3;
      expect_access(1'b0, 32'h0000_000E, 2'd2, 32'h0, 1'b0);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'hE; cpu_size = 2'd2;
      @(negedge clk);
      cpu_req = 1'b0;
      while (!(av_read && av_address == 32'h10)) @(negedge clk);
      check(av_waitrequest, "R1", "upper half stalled before reset",
            64'(av_waitrequest), 64'h1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!av_read && !av_write && !cpu_ack, "R1", "bus released by reset",
            {61'h0, av_read, av_write, cpu_ack}, 64'h0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!av_read && !av_write && !cpu_ack, "R1", "split resumed",
               {61'h0, av_read, av_write, cpu_ack}, 64'h0);
      end

      // recovery after reset, back-to-back with the acknowledge (R9)
      access(1'b0, 32'h0000_000D, 2'd1, 32'h0, 0);
      access(1'b1, 32'h0000_0013, 2'd1, 32'h0000_BEEF, 0);
      access(1'b0, 32'h0000_0012, 2'd2, 32'h0, 1);
      @(negedge clk);
      @(negedge clk);

      check(xq.size() == 0, "R7", "transfers left over", 64'(xq.size()), 64'h0);
      check(aq.size() == 0, "R9", "acks left over", 64'(aq.size()), 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule